// File: doc/BRIEF.md
# Eight-Line Port Controller with Alternate Outputs and Capture Inputs

This block controls an eight-line general-purpose I/O port. A small register bus, selected by a two-bit register select and a write strobe, reaches four registers. Three of them set the port: the output latch, the line direction and the open-drain mode. The fourth sets the edge mode of each capture line. For each line the block drives an output value and an output enable toward an external pad model. It also takes the pad level back in through a synchroniser.

The low four lines carry four pulse-width channels. On these lines the latch bit is combined with the channel by exclusive-or, so the latch either passes the waveform as it is or inverts it. The high four lines carry compare outputs, which are combined with the latch by AND. The same high lines are capture inputs. They are sampled at a slow fixed rate, compared with the previous sample, and raise a one-cycle event pulse when the selected kind of edge is seen. A system integrator connects the pulse-width unit, the compare unit and an interrupt controller to these ports.

Top module: `gpio_altport`

## Requirements
- R1: After reset, all four registers read 00h, no line is driven (pad_oe is 00h) and no capture event is raised.
- R2: A line with direction bit 0 is an input and is not driven. A line with direction bit 1 in push-pull mode has its enable asserted.
- R3: A line whose open-drain bit is 1 is driven only while its output value is 0, and then drives 0. When its value is 1 the line is released.
- R4: On lines 0 to 3 the output value is latch bit XOR the matching pulse-width channel, for channels 0 to 3.
- R5: When a pulse-width channel's enable is low, that channel contributes 0, so its line outputs the latch bit.
- R6: On lines 4 to 7, with the line's compare enable high, the output is latch bit AND compare channel (channels 0 to 3 map to lines 4 to 7). With the enable low, the output is the latch bit.
- R7: The register select codes are: 0 for the latch, 1 for direction, 2 for open-drain and 3 for edge mode. A write lands on the clock edge where wr_en is high. Reading the direction, open-drain and edge registers returns their contents combinationally.
- R8: Reading select 0 returns the latch bit on output lines and the synchronised pad level on input lines.
- R9: Each capture line passes through two synchronising flops and is sampled once every 8 clocks. A qualifying edge gives exactly one cap_evt pulse, one clock wide, no more than 11 clocks after the pad changes.
- R10: Edge mode bits [2k+1:2k] serve line 4+k. The codes are: 00 for no event, 01 for a rising edge, 10 for a falling edge and 11 for either edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| sel | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| pin_in | input | 8 | Pad levels returned from the pad model |
| pwm_out | input | 4 | Pulse-width channel outputs |
| pwm_en | input | 4 | Pulse-width channel enables |
| cmp_out | input | 4 | Compare channel outputs |
| cmp_en | input | 4 | Compare channel enables |
| pad_out | output | 8 | Output value per line |
| pad_oe | output | 8 | Output enable per line |
| cap_evt | output | 4 | Capture event pulses for lines 4 to 7 |

## Verification
Some behaviours are checked by the embedded assertions on every cycle. An undriven input line never has its enable set. An open-drain line that is driven always drives 0. A disabled pulse-width channel leaves its line at the latch value. A direction write lands one edge later. Every event pulse is one cycle wide and comes right after a sample tick. Other behaviours only the bench scenarios can show: the exclusive-or and AND combinations under chosen patterns, the mixed readback of latch and pad, and the reset values. The same holds for the four edge modes, each met with both rising and falling stimuli, and for the bound on event latency.

// File: rtl/gpio_altport_pkg.sv
package gpio_altport_pkg;

   typedef enum logic [1:0] {
      REG_LATCH = 2'd0,
      REG_DIR   = 2'd1,
      REG_ODC   = 2'd2,
      REG_EDGE  = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_mode_e;

   // true when the transition prev->cur matches the mode
   function automatic logic edge_hit(logic [1:0] mode, logic prev, logic cur);
      return (mode[0] & ~prev & cur) | (mode[1] & prev & ~cur);
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   generate
      genvar s;
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[0] <= '0;
               else        chain_q[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[s] <= '0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_altport_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int ECW   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       sel,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] pin_sync,
   output logic [WIDTH-1:0] latch_q,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] odc_q,
   output logic [ECW-1:0]   edge_q,
   output logic [WIDTH-1:0] rdata
);

   reg_sel_e sel_e;
   assign sel_e = reg_sel_e'(sel);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
         odc_q   <= '0;
         edge_q  <= '0;
      end else if (wr_en) begin
         case (sel_e)
            REG_LATCH: latch_q <= wdata;
            REG_DIR:   dir_q   <= wdata;
            REG_ODC:   odc_q   <= wdata;
            REG_EDGE:  edge_q  <= wdata[ECW-1:0];
            default:   ;
         endcase
      end
   end

   logic [WIDTH-1:0] edge_wide;
   generate
      if (ECW < WIDTH) begin : g_pad
         assign edge_wide = {{(WIDTH-ECW){1'b0}}, edge_q};
      end else begin : g_full
         assign edge_wide = edge_q;
      end
   endgenerate

   always_comb begin
      case (sel_e)
         REG_LATCH: rdata = (latch_q & dir_q) | (pin_sync & ~dir_q);
         REG_DIR:   rdata = dir_q;
         REG_ODC:   rdata = odc_q;
         REG_EDGE:  rdata = edge_wide;
         default:   rdata = '0;
      endcase
   end

   // R7
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == 2'd1) |=> (dir_q == $past(wdata)));

   // R7
   odc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en) |=> $stable(odc_q));

endmodule

// File: rtl/gpio_outmux.sv
module gpio_outmux #(
   parameter int NLINES = 8,
   parameter int NPWM   = 4
) (
   input  logic [NLINES-1:0]      latch_q,
   input  logic [NLINES-1:0]      dir_q,
   input  logic [NLINES-1:0]      odc_q,
   input  logic [NPWM-1:0]        pwm_out,
   input  logic [NPWM-1:0]        pwm_en,
   input  logic [NLINES-NPWM-1:0] cmp_out,
   input  logic [NLINES-NPWM-1:0] cmp_en,
   output logic [NLINES-1:0]      pad_out,
   output logic [NLINES-1:0]      pad_oe
);

   logic [NLINES-1:0] line_val;

   generate
      genvar i;
      for (i = 0; i < NLINES; i++) begin : g_line
         if (i < NPWM) begin : g_xor
            assign line_val[i] = latch_q[i] ^ (pwm_out[i] & pwm_en[i]);
         end else begin : g_and
            assign line_val[i] = cmp_en[i-NPWM] ? (latch_q[i] & cmp_out[i-NPWM])
                                                : latch_q[i];
         end
         // open drain: drive only a low level
         assign pad_oe[i]  = dir_q[i] & ~(odc_q[i] & line_val[i]);
         assign pad_out[i] = line_val[i];
      end
   endgenerate

endmodule

// File: rtl/gpio_capture.sv
module gpio_capture
   import gpio_altport_pkg::*;
#(
   parameter int NCAP = 4,
   parameter int DIV  = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCAP-1:0] cap_sync,
   input  logic [2*NCAP-1:0] edge_cfg,
   output logic [NCAP-1:0] cap_evt
);

   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   logic [CW-1:0]   cnt_q;
   logic            tick;
   logic [NCAP-1:0] samp_q;

   assign tick = (cnt_q == CW'(DIV - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end

   generate
      genvar k;
      for (k = 0; k < NCAP; k++) begin : g_cap
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               samp_q[k]  <= 1'b0;
               cap_evt[k] <= 1'b0;
            end else begin
               cap_evt[k] <= tick & edge_hit(edge_cfg[2*k +: 2], samp_q[k], cap_sync[k]);
               if (tick) samp_q[k] <= cap_sync[k];
            end
         end
      end
   endgenerate

   // R9
   evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_evt != '0) |=> (cap_evt == '0));

   // R9
   evt_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_evt != '0) |-> $past(tick));

endmodule

// File: rtl/gpio_altport.sv
module gpio_altport
   import gpio_altport_pkg::*;
#(
   parameter int NLINES      = 8,
   parameter int NPWM        = 4,
   parameter int NCAP        = 4,
   parameter int SAMPLE_DIV  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        sel,
   input  logic [NLINES-1:0] wdata,
   output logic [NLINES-1:0] rdata,
   input  logic [NLINES-1:0] pin_in,
   input  logic [NPWM-1:0]   pwm_out,
   input  logic [NPWM-1:0]   pwm_en,
   input  logic [NCAP-1:0]   cmp_out,
   input  logic [NCAP-1:0]   cmp_en,
   output logic [NLINES-1:0] pad_out,
   output logic [NLINES-1:0] pad_oe,
   output logic [NCAP-1:0]   cap_evt
);

   localparam int ECW = 2 * NCAP;

   generate
      if (NLINES != NPWM + NCAP) begin : g_bad_split
         $error("line count must equal pwm lines plus capture lines");
      end
      if (ECW > NLINES) begin : g_bad_edge
         $error("edge register does not fit the data width");
      end
      if (SAMPLE_DIV < 2) begin : g_bad_div
         $error("sample divider must be at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("at least one synchroniser stage is needed");
      end
   endgenerate

   logic [NLINES-1:0] pin_sync;
   logic [NLINES-1:0] latch_q, dir_q, odc_q;
   logic [ECW-1:0]    edge_q;

   gpio_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pin_in),
      .d_out (pin_sync)
   );

   gpio_regs #(.WIDTH(NLINES), .ECW(ECW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .sel      (sel),
      .wdata    (wdata),
      .pin_sync (pin_sync),
      .latch_q  (latch_q),
      .dir_q    (dir_q),
      .odc_q    (odc_q),
      .edge_q   (edge_q),
      .rdata    (rdata)
   );

   gpio_outmux #(.NLINES(NLINES), .NPWM(NPWM)) u_mux (
      .latch_q (latch_q),
      .dir_q   (dir_q),
      .odc_q   (odc_q),
      .pwm_out (pwm_out),
      .pwm_en  (pwm_en),
      .cmp_out (cmp_out),
      .cmp_en  (cmp_en),
      .pad_out (pad_out),
      .pad_oe  (pad_oe)
   );

   gpio_capture #(.NCAP(NCAP), .DIV(SAMPLE_DIV)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_sync (pin_sync[NLINES-1:NPWM]),
      .edge_cfg (edge_q),
      .cap_evt  (cap_evt)
   );

   // R2
   oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & ~dir_q) == '0));

   // R3
   od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & odc_q & pad_out) == '0));

   // R5
   pwm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (((pad_out[NPWM-1:0] ^ latch_q[NPWM-1:0]) & ~pwm_en) == '0));

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      (!rst_n) |=> (pad_oe == '0 && cap_evt == '0));

endmodule

// File: tb/gpio_altport_test.sv
`timescale 1ns/1ps
module gpio_altport_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] sel = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic [7:0] pin_in = 8'h00;
   logic [3:0] pwm_out = 4'h0;
   logic [3:0] pwm_en = 4'h0;
   logic [3:0] cmp_out = 4'h0;
   logic [3:0] cmp_en = 4'h0;
   logic [7:0] pad_out, pad_oe;
   logic [3:0] cap_evt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_altport uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(wdata),
      .rdata(rdata), .pin_in(pin_in), .pwm_out(pwm_out), .pwm_en(pwm_en),
      .cmp_out(cmp_out), .cmp_en(cmp_en), .pad_out(pad_out), .pad_oe(pad_oe),
      .cap_evt(cap_evt)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; sel = s; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   task automatic rd(input logic [1:0] s, output logic [7:0] d);
      @(negedge clk);
      sel = s;
      #1 d = rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #1;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      for (int s = 0; s < 4; s++) begin
         rd(2'(s), v);
         chk("R1 register reset", v, 8'h00);
      end
      chk("R1 pads released", pad_oe, 8'h00);
      chk("R1 no events", {4'h0, cap_evt}, 8'h00);
   endtask

   task automatic t_direction();
      logic [7:0] v;
      wr(2'd1, 8'hA5);
      rd(2'd1, v);
      chk("R7 direction readback", v, 8'hA5);
      chk("R2 enable follows direction", pad_oe, 8'hA5);
      wr(2'd2, 8'h3C);
      rd(2'd2, v);
      chk("R7 open-drain readback", v, 8'h3C);
      wr(2'd2, 8'h00);
      wr(2'd1, 8'h00);
      chk("R2 inputs undriven", pad_oe, 8'h00);
   endtask

   task automatic t_lower_xor();
      wr(2'd1, 8'hFF);
      wr(2'd0, 8'h05);
      pwm_out = 4'b0011; pwm_en = 4'hF; cmp_en = 4'h0;
      #1;
      chk("R4 xor pattern 1", pad_out, 8'h06);
      pwm_out = 4'b1100; #1;
      chk("R4 xor pattern 2", pad_out, 8'h09);
      pwm_en = 4'h0; #1;
      chk("R5 pwm disabled", pad_out, 8'h05);
      pwm_out = 4'b0011; pwm_en = 4'b0010; #1;
      chk("R5 partial enable", pad_out, 8'h07);
      pwm_en = 4'h0; pwm_out = 4'h0;
   endtask

   task automatic t_upper_and();
      wr(2'd0, 8'hF0);
      cmp_out = 4'b1010; cmp_en = 4'hF; #1;
      chk("R6 and with full latch", pad_out, 8'hA0);
      wr(2'd0, 8'h30);
      chk("R6 and with partial latch", pad_out, 8'h20);
      cmp_en = 4'h0; #1;
      chk("R6 compare disabled", pad_out, 8'h30);
      cmp_out = 4'h0;
   endtask

   task automatic t_open_drain();
      wr(2'd0, 8'h0F);
      wr(2'd2, 8'hFF);
      chk("R3 drive only low", pad_oe, 8'hF0);
      chk("R3 driven lines low", pad_out & pad_oe, 8'h00);
      wr(2'd1, 8'h3C);
      chk("R3 with direction mask", pad_oe, 8'h30);
      wr(2'd2, 8'h00);
      chk("R2 push-pull enable", pad_oe, 8'h3C);
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_readback();
      logic [7:0] v;
      wr(2'd1, 8'h0F);
      wr(2'd0, 8'h5A);
      pin_in = 8'hC3;
      idle(3);
      rd(2'd0, v);
      chk("R8 mixed readback", v, 8'hCA);
      pin_in = 8'h00;
      idle(3);
      rd(2'd0, v);
      chk("R8 pads low readback", v, 8'h0A);
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h00);
      idle(20);
   endtask

   // apply one pad transition on line 4+k and count event pulses
   task automatic cap_try(input int k, input logic lvl, input int exp_cnt, input string req);
      int cnt = 0;
      int first = -1;
      int other = 0;
      @(negedge clk);
      pin_in[4+k] = lvl;
      for (int c = 1; c <= 24; c++) begin
         @(negedge clk);
         #1;
         if (cap_evt[k]) begin
            cnt++;
            if (first < 0) first = c;
         end
         if ((cap_evt & ~(4'b1 << k)) != 4'h0) other++;
      end
      chk(req, 8'(cnt), 8'(exp_cnt));
      chk("R10 other lines quiet", 8'(other), 8'h00);
      if (exp_cnt > 0) chk("R9 latency bound", 8'(first <= 11 && first > 0), 8'h01);
   endtask

   task automatic t_capture();
      logic [7:0] v;
      for (int k = 0; k < 4; k += 3) begin
         wr(2'd3, 8'(2'b01 << (2*k)));
         rd(2'd3, v);
         chk("R7 edge readback", v, 8'(2'b01 << (2*k)));
         cap_try(k, 1'b1, 1, "R10 rising mode, rise");
         cap_try(k, 1'b0, 0, "R10 rising mode, fall");
         wr(2'd3, 8'(2'b10 << (2*k)));
         cap_try(k, 1'b1, 0, "R10 falling mode, rise");
         cap_try(k, 1'b0, 1, "R10 falling mode, fall");
         wr(2'd3, 8'(2'b11 << (2*k)));
         cap_try(k, 1'b1, 1, "R9 both mode, rise");
         cap_try(k, 1'b0, 1, "R9 both mode, fall");
         wr(2'd3, 8'h00);
         cap_try(k, 1'b1, 0, "R10 off mode, rise");
         cap_try(k, 1'b0, 0, "R10 off mode, fall");
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_direction();
      t_lower_xor();
      t_upper_and();
      t_open_drain();
      t_readback();
      t_capture();
      done = 1'b1;
      finish_run();
   end

endmodule